// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

A synchronous static RAM model with 36-bit words split into four 9-bit byte lanes and a parameterised depth. Address, write data and all controls except output enable and burst-order select are captured on the rising clock edge. The registered address drives the array combinationally, so read data appears in the cycle that follows the capturing edge, with no output register in the path.

A burst opens when either of two start strobes is seen with the chip selected. That edge loads the address. A 2-bit counter then moves through the other three words of the aligned group of four, one step for each cycle with the advance input high. The burst-order pin chooses between a wrapping increment and an XOR walk. Writes take effect on the same edge that captures the command. They can cover any subset of lanes or the whole word.

Top module: `fts_burst_sram`

## Requirements
- R1: After reset the data outputs are not driven (`q_drv` low) until a read cycle has been registered.
- R2: An edge with `sel` high and either `strb_cpu` or `strb_ctl` high loads `a_in`. After that edge, `q` holds the word at that address and `q_drv` is high when `oe` is high.
- R3: With `ilv` low, the two low address bits after k advances equal (start + k) mod 4. The upper address bits stay unchanged for the whole burst.
- R4: With `ilv` high, the two low address bits after k advances equal start XOR k.
- R5: The burst counter steps only on edges where `adv` is high and no strobe is present. Otherwise the address is held.
- R6: With `we` high, each lane i whose `bsel[i]` is high (bits 9i+8 down to 9i) takes `d_in`. The other lanes keep their contents.
- R7: `gwe` high writes all four lanes, whatever `we` and `bsel` are. `we` high with `bsel` = 4'b1111 also writes the whole word.
- R8: `bsel` with both `we` and `gwe` low writes nothing, and the cycle is a read.
- R9: A write is applied at the edge that captures it, to that edge's burst address. In the following cycle `q_drv` is low.
- R10: `oe` gates `q_drv` combinationally, with no clock edge needed.
- R11: A strobe edge with `sel` low deselects the chip. `q_drv` is low in the very next cycle, and `adv` has no effect until a new burst starts.
- R12: When a strobe and `adv` come on the same edge, the strobe wins and the burst starts at `a_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | AW | Word address |
| d_in | input | 36 | Write data, four 9-bit lanes |
| strb_cpu | input | 1 | Processor-side burst start strobe |
| strb_ctl | input | 1 | Controller-side burst start strobe |
| adv | input | 1 | Burst advance |
| sel | input | 1 | Chip select, sampled with a strobe |
| we | input | 1 | Write enable for selected lanes |
| gwe | input | 1 | Global write, all lanes |
| bsel | input | 4 | Lane selects |
| ilv | input | 1 | Burst order: 0 linear, 1 interleaved (not registered) |
| oe | input | 1 | Asynchronous output enable |
| q | output | 36 | Flow-through read data |
| q_drv | output | 1 | High when q is driven; low stands for high impedance |

## Verification
Two things can happen on the same edge: starting or stepping a burst, and writing a word. In that case the write must land on the address the burst logic produces at that edge, not on the address left over from the previous cycle. The bench creates this case by filling memory with strobe and global-write together, followed by advance-with-write steps in both burst orders. It then reads every location back in fresh bursts and compares against its own model. A strobe arriving together with advance is checked the same way, by reading the word at the strobe's address.

// File: rtl/fts_sram_pkg.sv
`timescale 1ns/1ps
package fts_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // Low address bits of a burst step: wrapping add or XOR walk
  function automatic logic [1:0] burst_lo(input logic [1:0] first,
                                          input logic [1:0] step,
                                          input logic       ileave);
    return ileave ? (first ^ step) : (first + step);
  endfunction

  // Lanes touched by a write command
  function automatic logic [LANES-1:0] lane_mask(input logic gwe,
                                                 input logic we,
                                                 input logic [LANES-1:0] bsel);
    if (gwe)     return {LANES{1'b1}};
    else if (we) return bsel;
    else         return '0;
  endfunction
endpackage

// File: rtl/fts_burst_seq.sv
`timescale 1ns/1ps
module fts_burst_seq import fts_sram_pkg::*; #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_in,
  input  logic          strb_any,
  input  logic          sel,
  input  logic          adv,
  input  logic          ilv,
  output logic          start_evt,
  output logic          desel_evt,
  output logic          adv_evt,
  output logic          active,
  output logic [1:0]    burst_cnt,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] next_addr
);
  localparam int HI_W = AW - 2;

  logic [HI_W-1:0] base_hi;
  logic [1:0]      base_lo;
  logic [1:0]      cnt_nx;

  assign start_evt = strb_any & sel;
  assign desel_evt = strb_any & ~sel;
  assign adv_evt   = active & adv & ~strb_any;
  assign cnt_nx    = burst_cnt + 2'd1;

  assign cur_addr  = {base_hi, burst_lo(base_lo, burst_cnt, ilv)};

  always_comb begin
    if (start_evt)    next_addr = a_in;
    else if (adv_evt) next_addr = {base_hi, burst_lo(base_lo, cnt_nx, ilv)};
    else              next_addr = cur_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi   <= '0;
      base_lo   <= '0;
      burst_cnt <= '0;
      active    <= 1'b0;
    end else if (start_evt) begin
      base_hi   <= a_in[AW-1:2];
      base_lo   <= a_in[1:0];
      burst_cnt <= '0;
      active    <= 1'b1;
    end else if (desel_evt) begin
      active    <= 1'b0;
    end else if (adv_evt) begin
      burst_cnt <= cnt_nx;
    end
  end
endmodule

// File: rtl/fts_wr_decode.sv
`timescale 1ns/1ps
module fts_wr_decode import fts_sram_pkg::*; (
  input  logic             go_ok,
  input  logic             gwe,
  input  logic             we,
  input  logic [LANES-1:0] bsel,
  output logic [LANES-1:0] wr_lanes,
  output logic             wr_go
);
  assign wr_lanes = go_ok ? lane_mask(gwe, we, bsel) : '0;
  assign wr_go    = |wr_lanes;
endmodule

// File: rtl/fts_mem_array.sv
`timescale 1ns/1ps
module fts_mem_array import fts_sram_pkg::*; #(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic [AW-1:0]     wr_addr,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
  end
endmodule

// File: rtl/fts_burst_sram.sv
`timescale 1ns/1ps
module fts_burst_sram import fts_sram_pkg::*; #(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     a_in,
  input  logic [WORD_W-1:0] d_in,
  input  logic              strb_cpu,
  input  logic              strb_ctl,
  input  logic              adv,
  input  logic              sel,
  input  logic              we,
  input  logic              gwe,
  input  logic [LANES-1:0]  bsel,
  input  logic              ilv,
  input  logic              oe,
  output logic [WORD_W-1:0] q,
  output logic              q_drv
);
  // Internal events, named for the checker
  logic             strb_any;
  logic             start_evt;
  logic             desel_evt;
  logic             adv_evt;
  logic             active;
  logic [1:0]       burst_cnt;
  logic [AW-1:0]    cur_addr;
  logic [AW-1:0]    next_addr;
  logic [LANES-1:0] wr_lanes;
  logic             wr_go;
  logic             wr_cyc;

  assign strb_any = strb_cpu | strb_ctl;

  fts_burst_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_in      (a_in),
    .strb_any  (strb_any),
    .sel       (sel),
    .adv       (adv),
    .ilv       (ilv),
    .start_evt (start_evt),
    .desel_evt (desel_evt),
    .adv_evt   (adv_evt),
    .active    (active),
    .burst_cnt (burst_cnt),
    .cur_addr  (cur_addr),
    .next_addr (next_addr)
  );

  fts_wr_decode u_dec (
    .go_ok    (start_evt | (active & ~strb_any)),
    .gwe      (gwe),
    .we       (we),
    .bsel     (bsel),
    .wr_lanes (wr_lanes),
    .wr_go    (wr_go)
  );

  fts_mem_array #(.AW(AW)) u_mem (
    .clk      (clk),
    .wr_addr  (next_addr),
    .wr_lanes (wr_lanes),
    .wr_data  (d_in),
    .rd_addr  (cur_addr),
    .rd_data  (q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_cyc <= 1'b0;
    else        wr_cyc <= wr_go;
  end

  assign q_drv = active & ~wr_cyc & oe;
endmodule

// File: rtl/fts_burst_sram_chk.sv
`timescale 1ns/1ps
module fts_burst_sram_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] a_in,
  input logic          oe,
  input logic          q_drv,
  input logic          start_evt,
  input logic          desel_evt,
  input logic          adv_evt,
  input logic          wr_go,
  input logic [1:0]    burst_cnt,
  input logic [AW-1:0] cur_addr
);
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n) start_evt |=> cur_addr == $past(a_in)); // R2
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n) !start_evt |=> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])); // R3
  AST_ADV_STEPS: assert property (@(posedge clk) disable iff (!rst_n) adv_evt |=> burst_cnt == $past(burst_cnt) + 2'd1); // R5
  AST_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!start_evt && !adv_evt) |=> burst_cnt == $past(burst_cnt)); // R5
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) wr_go |=> !q_drv); // R9
  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n) !oe |-> !q_drv); // R10
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) desel_evt |=> !q_drv); // R11
endmodule

bind fts_burst_sram fts_burst_sram_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_in      (a_in),
  .oe        (oe),
  .q_drv     (q_drv),
  .start_evt (start_evt),
  .desel_evt (desel_evt),
  .adv_evt   (adv_evt),
  .wr_go     (wr_go),
  .burst_cnt (burst_cnt),
  .cur_addr  (cur_addr)
);

// File: tb/sim_fts_burst_sram.sv
`timescale 1ns/1ps
module sim_fts_burst_sram;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] a_in;
  logic [35:0]   d_in;
  logic          strb_cpu, strb_ctl, adv, sel, we, gwe, ilv, oe;
  logic [3:0]    bsel;
  logic [35:0]   q;
  logic          q_drv;

  logic [35:0]   model [256];
  int            nchk = 0;
  int            nerr = 0;

  always #2.5 clk = ~clk;

  fts_burst_sram #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .d_in(d_in),
    .strb_cpu(strb_cpu), .strb_ctl(strb_ctl), .adv(adv), .sel(sel),
    .we(we), .gwe(gwe), .bsel(bsel), .ilv(ilv), .oe(oe),
    .q(q), .q_drv(q_drv)
  );

  function automatic logic [35:0] pat(input logic [7:0] a, input logic [3:0] salt);
    return {a, salt, a ^ 8'h5A, ~a, 4'h3 ^ salt, a + 8'd17};
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    strb_cpu = 0; strb_ctl = 0; adv = 0; we = 0; gwe = 0; bsel = 4'h0; sel = 1;
  endtask

  task automatic t_reset();
    rst_n = 0; idle_in(); oe = 1; ilv = 0; a_in = '0; d_in = '0;
    repeat (3) step();
    rst_n = 1;
    step();
    check("R1 idle after reset", {35'd0, q_drv}, 36'd0);
  endtask

  // Burst write with strobe+write, then advance+write: concurrency case
  task automatic t_fill(input logic [7:0] start, input logic order, input logic [3:0] salt);
    logic [7:0] ad;
    idle_in(); ilv = order;
    a_in = start; strb_ctl = order; strb_cpu = ~order; gwe = 1; d_in = pat(start, salt);
    step();
    model[start] = pat(start, salt);
    check("R9 quiet after write", {35'd0, q_drv}, 36'd0);
    strb_cpu = 0; strb_ctl = 0; adv = 1;
    for (int k = 1; k < 4; k++) begin
      ad = order ? {start[7:2], start[1:0] ^ 2'(k)} : {start[7:2], start[1:0] + 2'(k)};
      d_in = pat(ad, salt);
      step();
      model[ad] = pat(ad, salt);
      check("R9 quiet on burst write", {35'd0, q_drv}, 36'd0);
    end
    idle_in(); ilv = 0;
  endtask

  task automatic t_read_burst(input logic [7:0] start, input logic order, input string req);
    logic [7:0] ad;
    idle_in(); ilv = order;
    a_in = start; strb_cpu = 1;
    step();
    check("R2 flow-through first word", q, model[start]);
    check("R2 driven on read", {35'd0, q_drv}, 36'd1);
    strb_cpu = 0; adv = 1;
    for (int k = 1; k < 4; k++) begin
      ad = order ? {start[7:2], start[1:0] ^ 2'(k)} : {start[7:2], start[1:0] + 2'(k)};
      step();
      check(req, q, model[ad]);
    end
    idle_in(); ilv = 0;
  endtask

  task automatic t_suspend();
    idle_in(); a_in = 8'h4C; strb_ctl = 1;
    step();
    strb_ctl = 0;
    step();
    check("R5 hold without adv", q, model[8'h4C]);
    step();
    check("R5 hold second cycle", q, model[8'h4C]);
    adv = 1;
    step();
    check("R5 step with adv", q, model[8'h4D]);
    idle_in();
  endtask

  task automatic t_byte_write();
    idle_in(); a_in = 8'h49; strb_cpu = 1; we = 1; bsel = 4'b0101; d_in = '1;
    step();
    model[8'h49][8:0]   = 9'h1FF;
    model[8'h49][26:18] = 9'h1FF;
    check("R9 quiet after byte write", {35'd0, q_drv}, 36'd0);
    idle_in(); a_in = 8'h49; strb_cpu = 1;
    step();
    check("R6 lanes 0 and 2 only", q, model[8'h49]);
    idle_in();
  endtask

  task automatic t_no_write_enable();
    idle_in(); a_in = 8'h4A; strb_cpu = 1; bsel = 4'b1111; d_in = '0;
    step();
    check("R8 bsel alone is a read", q, model[8'h4A]);
    check("R8 output driven", {35'd0, q_drv}, 36'd1);
    idle_in();
    step();
    check("R8 contents unchanged", q, model[8'h4A]);
  endtask

  task automatic t_global();
    idle_in(); a_in = 8'h4B; strb_ctl = 1; gwe = 1; bsel = 4'h0; d_in = pat(8'h4B, 4'hE);
    step();
    model[8'h4B] = pat(8'h4B, 4'hE);
    idle_in(); a_in = 8'h4B; strb_ctl = 1;
    step();
    check("R7 global write all lanes", q, model[8'h4B]);
    idle_in(); a_in = 8'h4B; strb_ctl = 1; we = 1; bsel = 4'hF; d_in = pat(8'h4B, 4'h7);
    step();
    model[8'h4B] = pat(8'h4B, 4'h7);
    idle_in(); a_in = 8'h4B; strb_ctl = 1;
    step();
    check("R7 all selects plus we", q, model[8'h4B]);
    idle_in();
  endtask

  task automatic t_oe();
    idle_in(); a_in = 8'h48; strb_cpu = 1;
    step();
    idle_in();
    check("R10 driven with oe", {35'd0, q_drv}, 36'd1);
    oe = 0; #1;
    check("R10 oe low releases", {35'd0, q_drv}, 36'd0);
    oe = 1; #1;
    check("R10 oe high drives", {35'd0, q_drv}, 36'd1);
  endtask

  task automatic t_deselect();
    idle_in(); sel = 0; strb_cpu = 1;
    step();
    check("R11 released next cycle", {35'd0, q_drv}, 36'd0);
    idle_in(); adv = 1;
    step();
    check("R11 adv while deselected", {35'd0, q_drv}, 36'd0);
    idle_in();
  endtask

  task automatic t_priority();
    idle_in(); a_in = 8'h4E; strb_ctl = 1; adv = 1;
    step();
    check("R12 strobe beats adv", q, model[8'h4E]);
    idle_in();
  endtask

  initial begin
    t_reset();
    t_fill(8'h48, 1'b0, 4'h1);
    t_fill(8'h4D, 1'b1, 4'h2);
    t_read_burst(8'h49, 1'b0, "R3 linear order");
    t_read_burst(8'h4E, 1'b1, "R4 interleaved order");
    t_suspend();
    t_byte_write();
    t_no_write_enable();
    t_global();
    t_oe();
    t_deselect();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog act running exp finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule